// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Blocking Transmit

This block joins a 32-bit valid/ready memory bus to a pair of asynchronous serial lines. Frames use eight data bits, no parity and one stop bit; the default bit rate is 115200 baud from a 50 MHz clock. The bus sees a 16-byte window in which every address behaves the same. A read returns one word that holds both the oldest received byte and a flag saying whether that byte is real. A write sends the low byte of the data word at once. The bus handshake stays open until the last stop bit has left the pin.

Incoming frames are oversampled, checked at mid-bit and placed in a small receive queue. The transmit side has no buffer: software paces itself through the stalled write, so a completed write always means an idle line.

Top module: `uart_mmio`

## Requirements
- R1: One bit time is CLK_HZ/BAUD clock cycles (434 at the defaults). A transmitted frame is a low start bit, then data bits 0 to 7 (least significant first), then a high stop bit. `txd` is high whenever no frame is being sent.
- R2: A write (`mem_valid`=1, `mem_write`=1) is taken at the first clock edge where `mem_ready` is low and no frame is in flight. `txd` goes low after that edge. `mem_ready` is high for exactly one cycle, starting ten bit times after the accepting edge, when the stop bit has ended. It is never high earlier.
- R3: A read (`mem_valid`=1, `mem_write`=0) is answered with `mem_ready` high for exactly one cycle, in the cycle after the accepting edge, with `mem_rdata` valid in that cycle.
- R4: A read with a byte queued returns bit 15 = 1 and the oldest byte in bits [7:0], and it removes that byte from the queue. Bits [31:16] and [14:8] are always 0.
- R5: A read with an empty queue returns bit 15 = 0 and changes nothing. The next byte received is the next byte read.
- R6: `mem_addr` has no effect: every offset in the window reads and writes the same port.
- R7: `rxd` passes through two synchronising flops. A low level confirmed half a bit time after the falling edge starts a frame. Data bits are sampled at mid-bit, least significant first.
- R8: A frame whose stop bit samples low is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: The queue holds DEPTH bytes and keeps arrival order. A valid frame that arrives while the queue is full is dropped.
- R10: A low pulse on `rxd` shorter than half a bit time is not taken as a start bit and queues nothing.
- R11: After reset `txd` is 1, `mem_ready` is 0 and the receive queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Bus request, held until `mem_ready` |
| mem_write | input | 1 | 1 = write (transmit), 0 = read (receive) |
| mem_addr | input | 4 | Offset inside the window, ignored |
| mem_wdata | input | 32 | Write data; bits [7:0] are sent |
| mem_rdata | output | 32 | Read data: bit 15 valid flag, bits [7:0] byte |
| mem_ready | output | 1 | One-cycle completion pulse |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The bound checker watches on every cycle that the completion pulse lasts one cycle, only follows a request and never appears while a frame is on the line. It also checks that the idle line stays high, that the padding bits of read data are zero, that an empty queue reports no data and that the queue count never exceeds its depth. Three kinds of behaviour need the bench's scenarios and its per-cycle model of the transmit pin: the exact bit pattern and the ten-bit-time stall, ordering through the queue, and the fate of a bad stop bit, a short glitch or an overflowing byte.

// File: rtl/uart_mmio.sv
module uart_mmio #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 115200,
  parameter int DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mem_valid,
  input  logic        mem_write,
  input  logic [3:0]  mem_addr,
  input  logic [31:0] mem_wdata,
  output logic [31:0] mem_rdata,
  output logic        mem_ready,
  input  logic        rxd,
  output logic        txd
);
  localparam int BIT  = CLK_HZ / BAUD;
  localparam int HALF = BIT / 2;
  localparam int CW   = $clog2(BIT);
  localparam int PW   = $clog2(DEPTH);

  wire unused_bus = ^{mem_addr, mem_wdata[31:8]};

  // receive queue
  logic [7:0]  q_mem [DEPTH];
  logic [PW:0] wptr, rptr;
  logic [PW:0] fifo_count;
  logic        q_push;
  logic [7:0]  q_din;
  assign fifo_count = wptr - rptr;
  wire q_empty = (fifo_count == '0);
  wire q_full  = (fifo_count == (PW+1)'(DEPTH));

  wire rd_go = mem_valid && !mem_write && !mem_ready;
  logic tx_busy;
  wire wr_go = mem_valid && mem_write && !mem_ready && !tx_busy;
  wire q_pop = rd_go && !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (q_push && !q_full) begin
        q_mem[wptr[PW-1:0]] <= q_din;
        wptr <= wptr + 1'b1;
      end
      if (q_pop) rptr <= rptr + 1'b1;
    end
  end

  // bus side and transmitter
  logic [8:0]    tx_sh;
  logic [3:0]    tx_idx;
  logic [CW-1:0] tx_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txd       <= 1'b1;
      tx_busy   <= 1'b0;
      tx_sh     <= '1;
      tx_idx    <= '0;
      tx_cnt    <= '0;
      mem_ready <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ready <= 1'b0;
      if (rd_go) begin
        mem_ready <= 1'b1;
        mem_rdata <= {16'b0, !q_empty, 7'b0, q_mem[rptr[PW-1:0]]};
      end
      if (wr_go) begin
        tx_busy <= 1'b1;
        txd     <= 1'b0;
        tx_sh   <= {1'b1, mem_wdata[7:0]};
        tx_idx  <= '0;
        tx_cnt  <= '0;
      end else if (tx_busy) begin
        if (tx_cnt == CW'(BIT-1)) begin
          tx_cnt <= '0;
          if (tx_idx == 4'd9) begin
            tx_busy   <= 1'b0;
            mem_ready <= 1'b1;
          end else begin
            txd    <= tx_sh[0];
            tx_sh  <= {1'b1, tx_sh[8:1]};
            tx_idx <= tx_idx + 1'b1;
          end
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end

  // receiver
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_t;
  rx_state_t     rx_st;
  logic [1:0]    rx_sync;
  logic [CW-1:0] rx_cnt;
  logic [2:0]    rx_idx;
  logic [7:0]    rx_sh;
  wire rx_s = rx_sync[1];
  assign q_din = rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      rx_st   <= RX_IDLE;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      q_push  <= 1'b0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      q_push  <= 1'b0;
      case (rx_st)
        RX_IDLE: begin
          rx_cnt <= '0;
          if (!rx_s) rx_st <= RX_START;
        end
        RX_START: begin
          if (rx_cnt == CW'(HALF-1)) begin
            rx_cnt <= '0;
            rx_idx <= '0;
            rx_st  <= rx_s ? RX_IDLE : RX_DATA;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        RX_DATA: begin
          if (rx_cnt == CW'(BIT-1)) begin
            rx_cnt <= '0;
            rx_sh  <= {rx_s, rx_sh[7:1]};
            rx_idx <= rx_idx + 1'b1;
            if (rx_idx == 3'd7) rx_st <= RX_STOP;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        RX_STOP: begin
          if (rx_cnt == CW'(BIT-1)) begin
            rx_cnt <= '0;
            q_push <= rx_s;
            rx_st  <= rx_s ? RX_IDLE : RX_HOLD;
          end else rx_cnt <= rx_cnt + 1'b1;
        end
        default: if (rx_s) rx_st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mem_valid,
  input logic                     mem_write,
  input logic                     mem_ready,
  input logic [31:0]              mem_rdata,
  input logic                     txd,
  input logic                     tx_busy,
  input logic [$clog2(DEPTH):0]   fifo_count
);
  assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> !mem_ready);

  assert_ready_after_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> $past(mem_valid));

  assert_stall_while_sending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !mem_ready);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_zero_padding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && !mem_write) |-> (mem_rdata[31:16] == 16'h0 && mem_rdata[14:8] == 7'h0));

  assert_empty_reports_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready && !mem_write && $past(fifo_count) == '0) |-> !mem_rdata[15]);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind uart_mmio uart_mmio_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_write(mem_write),
  .mem_ready(mem_ready), .mem_rdata(mem_rdata), .txd(txd),
  .tx_busy(tx_busy), .fifo_count(fifo_count)
);

// File: tb/test_uart_mmio.sv
module test_uart_mmio;
  localparam int BIT   = 16;
  localparam int DEPTH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_valid = 1'b0, mem_write = 1'b0;
  logic [3:0]  mem_addr = '0;
  logic [31:0] mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic mem_ready, rxd = 1'b1, txd;

  uart_mmio #(.CLK_HZ(50_000_000), .BAUD(50_000_000/BIT), .DEPTH(DEPTH)) i_uart_mmio (
    .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .rxd(rxd), .txd(txd));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference model of the transmit pin and completion pulse
  bit m_busy = 0, m_ready = 0;
  int m_t = 0;
  logic [9:0] m_frame = '1;
  logic [7:0] q[$];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      finish_run();
    end
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_t = 0;
    end else begin
      automatic bit nr = 0;
      if (m_busy) begin
        m_t++;
        if (m_t == 10*BIT) begin m_busy = 0; nr = 1; end
      end else if (mem_valid && mem_write && !m_ready) begin
        m_busy = 1; m_t = 0; m_frame = {1'b1, mem_wdata[7:0], 1'b0};
      end
      if (mem_valid && !mem_write && !m_ready) nr = 1;
      m_ready = nr;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic logic exp_tx = m_busy ? m_frame[m_t/BIT] : 1'b1;
      chk(txd === exp_tx, "R1 txd", int'(txd), int'(exp_tx));
      chk(mem_ready === m_ready, "R2/R3 mem_ready", int'(mem_ready), int'(m_ready));
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    int waited = 0;
    @(negedge clk);
    mem_valid = 1; mem_write = 1; mem_addr = a; mem_wdata = {24'hABCDEF, d};
    do begin @(negedge clk); waited++; end while (mem_ready !== 1'b1);
    chk(waited == 10*BIT + 1, "R2 stall length", waited, 10*BIT + 1);
    mem_valid = 0; mem_write = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, input string req);
    int waited = 0;
    logic [7:0] eb;
    bit ev;
    @(negedge clk);
    mem_valid = 1; mem_write = 0; mem_addr = a;
    do begin @(negedge clk); waited++; end while (mem_ready !== 1'b1);
    chk(waited == 1, {req, " R3 read latency"}, waited, 1);
    ev = (q.size() > 0);
    eb = ev ? q.pop_front() : 8'h00;
    chk(mem_rdata[15] == ev, {req, " valid flag"}, int'(mem_rdata[15]), int'(ev));
    if (ev) chk(mem_rdata[7:0] == eb, {req, " byte"}, int'(mem_rdata[7:0]), int'(eb));
    chk(mem_rdata[31:16] == 0 && mem_rdata[14:8] == 0, "R4 padding", int'(mem_rdata), 0);
    mem_valid = 0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit stop);
    logic [9:0] f = {stop, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (BIT-1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
    if (stop && q.size() < DEPTH) q.push_back(d);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1, "R11 txd after reset", int'(txd), 1);
    chk(mem_ready === 1'b0, "R11 ready after reset", int'(mem_ready), 0);
    bus_read(4'h0, "R11/R5 empty after reset");

    bus_write(4'h0, 8'hA5);
    bus_write(4'hF, 8'h3C);
    bus_write(4'h6, 8'h00);

    rx_frame(8'h5A, 1);
    bus_read(4'h7, "R7/R6 single byte");
    bus_read(4'h7, "R4 popped");

    rx_frame(8'h11, 1); rx_frame(8'h22, 1); rx_frame(8'h33, 1);
    bus_read(4'h3, "R4/R6 order 1");
    bus_read(4'h9, "R4/R6 order 2");
    bus_read(4'hC, "R4/R6 order 3");
    bus_read(4'h0, "R5 empty again");

    rx_frame(8'h77, 0);
    repeat (3*BIT) @(negedge clk);
    bus_read(4'h1, "R8 bad stop discarded");

    @(negedge clk); rxd = 0;
    repeat (BIT/2 - 2) @(negedge clk);
    rxd = 1;
    repeat (3*BIT) @(negedge clk);
    bus_read(4'h2, "R10 glitch ignored");

    rx_frame(8'h42, 1);
    bus_read(4'h5, "R5 no side effect");

    for (int i = 0; i < DEPTH + 2; i++) rx_frame(8'h81 + 8'(i), 1);
    for (int i = 0; i < DEPTH + 1; i++) bus_read(4'(i), "R9 full queue");

    bus_write(4'h8, 8'hFF);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule